// File: doc/BRIEF.md
# Write-Only Supply Voltage Setting Target on I2C

This block is a receive-only target on a two-wire I2C bus. It holds the setting codes for a dual-rail supply: one code for the positive rail, one for the mirrored negative rail, and a mode byte. A bus master addresses the target, sends a register pointer, and then sends one or more data bytes. The pointer advances by one after each data byte. The target acknowledges each byte it accepts by pulling the data line low for the ninth clock.

The raw clock and data lines are resynchronised to the system clock and filtered before edge detection. For this reason the system clock must run at least sixteen times faster than the bus clock. Read requests are never acknowledged. The interface is held idle while both rail enables are low. A power-on reset pulse, or the asynchronous reset, returns every register to its default. A parameter selects the variant and with it the default code.

Top module: `vsel_i2c_slave`

## Requirements
- R1: A first byte of 0111110 followed by R/W bit 0 (0x7C on the wire) is acknowledged, and the target then accepts a pointer byte and data bytes.
- R2: A first byte with R/W bit 1, or with any other 7-bit address, is not acknowledged. No later byte of that transfer is acknowledged or changes any register.
- R3: Pointer 0x00 holds the positive-rail code and pointer 0x01 holds the negative-rail code, both in data bits 4:0; bits 7:5 of the data are ignored. Codes 1 to 17 (4.1 V to 5.7 V in 0.1 V steps) are stored. Code 0 and codes 18 to 31 are acknowledged but leave the register unchanged.
- R4: After each data byte the pointer increments, so consecutive data bytes fill consecutive registers.
- R5: Pointer 0x03 is the mode byte. Its bits 1:0 always read as 1: a written value is stored with those two bits forced to 1, and the default is 0x03.
- R6: Data written to an unmapped pointer (for example 0x02) is acknowledged and discarded, and the pointer still increments.
- R7: After rst_ni or a one-cycle por_i pulse, both codes equal 10 when ALT_DEFAULT is 0, or 14 when it is 1, and the mode byte is 0x03.
- R8: While en_pos_i and en_neg_i are both low, no byte is acknowledged and no register changes. The target works when either enable is high.
- R9: A START or STOP that arrives before the eighth bit of a byte has been received aborts the transfer, and no register changes.
- R10: The acknowledge pull-down is active only during the ninth clock of an accepted byte. It is off while the eighth bit is high and is released after the ninth clock falls.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| por_i | input | 1 | Synchronous power-on reset pulse, restores defaults |
| en_pos_i | input | 1 | Positive-rail enable |
| en_neg_i | input | 1 | Negative-rail enable |
| scl_i | input | 1 | Raw bus clock line |
| sda_i | input | 1 | Raw bus data line (wired level) |
| sda_pull_o | output | 1 | High to pull the data line low for acknowledge |
| pos_code_o | output | 5 | Positive-rail setting code |
| neg_code_o | output | 5 | Negative-rail setting code |
| mode_o | output | 8 | Mode byte |

## Verification
The hardest situation to reach from the ports is a transfer cut off partway through a byte. The data line must change while the clock is high, after the target already holds a valid pointer. The bench clocks in only half a data byte after a correct address and pointer, then issues a STOP, and later a repeated START in the same position. After each abort it shows that the codes are unchanged and that a fresh transfer still works. The bench also places an unmapped pointer inside a multi-byte burst, so the discard and the pointer increment are seen together on the mode byte that follows.

// File: rtl/vsel_pkg.sv
package vsel_pkg;
  localparam int CODE_W = 5;
  localparam int CODE_MIN = 1;
  localparam int CODE_MAX = 17;
  localparam logic [7:0] PTR_POS  = 8'h00;
  localparam logic [7:0] PTR_NEG  = 8'h01;
  localparam logic [7:0] PTR_MODE = 8'h03;
  localparam logic [7:0] MODE_LOCK = 8'h03;

  typedef enum logic [1:0] {PH_IDLE, PH_ADDR, PH_PTR, PH_DATA} phase_e;

  function automatic logic [CODE_W-1:0] def_code(input bit alt);
    return alt ? CODE_W'(14) : CODE_W'(10);
  endfunction
endpackage

// File: rtl/vsel_glitch_filter.sv
module vsel_glitch_filter #(
  parameter int W = 2,
  parameter int STABLE = 3
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic [W-1:0] raw_i,
  output logic [W-1:0] filt_o
);
  localparam int CW = $clog2(STABLE) + 1;

  for (genvar g = 0; g < W; g++) begin : g_line
    logic [1:0] sync_q;
    logic [CW-1:0] cnt_q;
    logic filt_q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
        sync_q <= 2'b11;
        cnt_q  <= '0;
        filt_q <= 1'b1;
      end else begin
        sync_q <= {sync_q[0], raw_i[g]};
        if (sync_q[1] == filt_q) begin
          cnt_q <= '0;
        end else if (cnt_q == CW'(STABLE - 1)) begin
          filt_q <= sync_q[1];
          cnt_q  <= '0;
        end else begin
          cnt_q <= cnt_q + 1'b1;
        end
      end
    end
    assign filt_o[g] = filt_q;
  end
endmodule

// File: rtl/vsel_bus_rx.sv
module vsel_bus_rx
  import vsel_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR = 7'b0111110
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       clr_i,
  input  logic       scl_i,
  input  logic       sda_i,
  output logic       sda_pull_o,
  output logic       wr_o,
  output logic [7:0] wr_addr_o,
  output logic [7:0] wr_data_o
);
  phase_e     phase_q;
  logic [3:0] bit_cnt_q;
  logic [7:0] shreg_q, ptr_q;
  logic       scl_q, sda_q, ack_q;
  logic       start_w, stop_w, scl_rise, scl_fall;

  assign start_w  = scl_i && scl_q && sda_q && !sda_i;
  assign stop_w   = scl_i && scl_q && !sda_q && sda_i;
  assign scl_rise = scl_i && !scl_q;
  assign scl_fall = !scl_i && scl_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      phase_q   <= PH_IDLE;
      bit_cnt_q <= '0;
      shreg_q   <= '0;
      ptr_q     <= '0;
      scl_q     <= 1'b1;
      sda_q     <= 1'b1;
      ack_q     <= 1'b0;
      wr_o      <= 1'b0;
      wr_addr_o <= '0;
      wr_data_o <= '0;
    end else begin
      scl_q <= scl_i;
      sda_q <= sda_i;
      wr_o  <= 1'b0;
      if (clr_i || stop_w) begin
        phase_q   <= PH_IDLE;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (start_w) begin
        phase_q   <= PH_ADDR;
        bit_cnt_q <= '0;
        ack_q     <= 1'b0;
      end else if (phase_q != PH_IDLE) begin
        if (scl_rise) begin
          if (bit_cnt_q < 4'd8) shreg_q <= {shreg_q[6:0], sda_i};
          bit_cnt_q <= bit_cnt_q + 1'b1;
        end
        if (scl_fall && bit_cnt_q == 4'd8) begin
          unique case (phase_q)
            PH_ADDR: begin
              if (shreg_q[7:1] == DEV_ADDR && !shreg_q[0]) begin
                ack_q   <= 1'b1;
                phase_q <= PH_PTR;
              end else begin
                phase_q <= PH_IDLE;
              end
            end
            PH_PTR: begin
              ptr_q   <= shreg_q;
              ack_q   <= 1'b1;
              phase_q <= PH_DATA;
            end
            PH_DATA: begin
              wr_o      <= 1'b1;
              wr_addr_o <= ptr_q;
              wr_data_o <= shreg_q;
              ptr_q     <= ptr_q + 1'b1;
              ack_q     <= 1'b1;
            end
            default: phase_q <= PH_IDLE;
          endcase
        end
        if (scl_fall && bit_cnt_q == 4'd9) begin
          ack_q     <= 1'b0;
          bit_cnt_q <= '0;
        end
      end
    end
  end

  assign sda_pull_o = ack_q;
endmodule

// File: rtl/vsel_reg_bank.sv
module vsel_reg_bank
  import vsel_pkg::*;
#(
  parameter bit ALT_DEFAULT = 1'b0
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              wr_i,
  input  logic [7:0]        wr_addr_i,
  input  logic [7:0]        wr_data_i,
  output logic [CODE_W-1:0] pos_code_o,
  output logic [CODE_W-1:0] neg_code_o,
  output logic [7:0]        mode_o
);
  localparam logic [CODE_W-1:0] DEF = def_code(ALT_DEFAULT);

  logic [CODE_W-1:0] code_w;
  logic              code_ok;

  assign code_w  = wr_data_i[CODE_W-1:0];
  assign code_ok = (code_w >= CODE_W'(CODE_MIN)) && (code_w <= CODE_W'(CODE_MAX));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      pos_code_o <= DEF;
      neg_code_o <= DEF;
      mode_o     <= MODE_LOCK;
    end else if (por_i) begin
      pos_code_o <= DEF;
      neg_code_o <= DEF;
      mode_o     <= MODE_LOCK;
    end else if (wr_i) begin
      if (wr_addr_i == PTR_POS && code_ok) pos_code_o <= code_w;
      if (wr_addr_i == PTR_NEG && code_ok) neg_code_o <= code_w;
      if (wr_addr_i == PTR_MODE)           mode_o     <= wr_data_i | MODE_LOCK;
    end
  end
endmodule

// File: rtl/vsel_i2c_slave.sv
module vsel_i2c_slave
  import vsel_pkg::*;
#(
  parameter logic [6:0] DEV_ADDR    = 7'b0111110,
  parameter bit         ALT_DEFAULT = 1'b0,
  parameter int         FILT_LEN    = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              por_i,
  input  logic              en_pos_i,
  input  logic              en_neg_i,
  input  logic              scl_i,
  input  logic              sda_i,
  output logic              sda_pull_o,
  output logic [CODE_W-1:0] pos_code_o,
  output logic [CODE_W-1:0] neg_code_o,
  output logic [7:0]        mode_o
);
  logic [1:0] line_f;
  logic       standby, wr;
  logic [7:0] wr_addr, wr_data;

  assign standby = !en_pos_i && !en_neg_i;

  vsel_glitch_filter #(.W(2), .STABLE(FILT_LEN)) u_filt (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .raw_i  ({scl_i, sda_i}),
    .filt_o (line_f)
  );

  vsel_bus_rx #(.DEV_ADDR(DEV_ADDR)) u_rx (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .clr_i      (standby || por_i),
    .scl_i      (line_f[1]),
    .sda_i      (line_f[0]),
    .sda_pull_o (sda_pull_o),
    .wr_o       (wr),
    .wr_addr_o  (wr_addr),
    .wr_data_o  (wr_data)
  );

  vsel_reg_bank #(.ALT_DEFAULT(ALT_DEFAULT)) u_regs (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .por_i      (por_i),
    .wr_i       (wr),
    .wr_addr_i  (wr_addr),
    .wr_data_i  (wr_data),
    .pos_code_o (pos_code_o),
    .neg_code_o (neg_code_o),
    .mode_o     (mode_o)
  );
endmodule

// File: rtl/vsel_i2c_slave_chk.sv
module vsel_i2c_slave_chk #(
  parameter bit ALT_DEFAULT = 1'b0
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       por_i,
  input logic       en_pos_i,
  input logic       en_neg_i,
  input logic       sda_pull_o,
  input logic [4:0] pos_code_o,
  input logic [4:0] neg_code_o,
  input logic [7:0] mode_o
);
  localparam logic [4:0] DEF = ALT_DEFAULT ? 5'd14 : 5'd10;
  logic sb;
  assign sb = !en_pos_i && !en_neg_i;

  AST_CODE_RANGE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pos_code_o >= 5'd1 && pos_code_o <= 5'd17 && neg_code_o >= 5'd1 && neg_code_o <= 5'd17); // R3
  AST_MODE_LOCKED: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode_o[1:0] == 2'b11); // R5
  AST_POR_DEFAULTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    por_i |=> (pos_code_o == DEF && neg_code_o == DEF && mode_o == 8'h03)); // R7
  AST_STANDBY_NO_ACK: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb && $past(sb)) |-> !sda_pull_o); // R8
  AST_STANDBY_FROZEN: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sb && $past(sb) && !por_i) |=> ($stable(pos_code_o) && $stable(neg_code_o) && $stable(mode_o))); // R8
endmodule

bind vsel_i2c_slave vsel_i2c_slave_chk #(.ALT_DEFAULT(ALT_DEFAULT)) u_chk (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .por_i      (por_i),
  .en_pos_i   (en_pos_i),
  .en_neg_i   (en_neg_i),
  .sda_pull_o (sda_pull_o),
  .pos_code_o (pos_code_o),
  .neg_code_o (neg_code_o),
  .mode_o     (mode_o)
);

// File: tb/vsel_i2c_slave_tb.sv
module vsel_i2c_slave_tb;
  localparam bit ALT = 1'b0;
  localparam logic [4:0] DEF = ALT ? 5'd14 : 5'd10;
  localparam int Q = 25;
  localparam logic [7:0] AW = 8'h7C;

  logic clk = 1'b0, rst_n = 1'b0, por = 1'b0;
  logic en_p = 1'b1, en_n = 1'b1, scl = 1'b1, sda_m = 1'b1;
  logic pull;
  logic [4:0] pos, neg;
  logic [7:0] mode;
  wire sda_line = sda_m & ~pull;
  int checks = 0, errors = 0;

  always #10 clk = ~clk;

  vsel_i2c_slave #(.ALT_DEFAULT(ALT)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .por_i(por), .en_pos_i(en_p), .en_neg_i(en_n),
    .scl_i(scl), .sda_i(sda_line), .sda_pull_o(pull),
    .pos_code_o(pos), .neg_code_o(neg), .mode_o(mode));

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic b_start();
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b0; wq(Q); scl = 1'b0; wq(Q);
  endtask

  task automatic b_stop();
    sda_m = 1'b0; wq(Q); scl = 1'b1; wq(Q); sda_m = 1'b1; wq(2 * Q);
  endtask

  task automatic b_bits(input logic [7:0] b, input int n);
    for (int i = 7; i > 7 - n; i--) begin
      sda_m = b[i]; wq(Q); scl = 1'b1; wq(Q);
      if (i == 0) chk("R10 no pull on bit 8", pull, 0);
      wq(Q); scl = 1'b0; wq(Q);
    end
  endtask

  task automatic b_byte(input logic [7:0] b, input bit exp_ack, input string req);
    b_bits(b, 8);
    sda_m = 1'b1; wq(Q); scl = 1'b1; wq(Q);
    chk(req, !sda_line, exp_ack);
    wq(Q); scl = 1'b0; wq(Q);
    chk("R10 released after ninth", pull, 0);
  endtask

  task automatic t_reset();
    chk("R7 pos default", pos, DEF);
    chk("R7 neg default", neg, DEF);
    chk("R7 mode default", mode, 8'h03);
    chk("R10 idle pull", pull, 0);
  endtask

  task automatic t_write_basic();
    b_start(); b_byte(AW, 1, "R1 addr ack"); b_byte(8'h00, 1, "R1 ptr ack");
    b_byte(8'd15, 1, "R1 data ack"); b_stop();
    chk("R1 pos written", pos, 15);
  endtask

  task automatic t_burst();
    b_start(); b_byte(AW, 1, "R4 addr"); b_byte(8'h00, 1, "R4 ptr");
    b_byte(8'd12, 1, "R4 d0"); b_byte(8'd7, 1, "R4 d1"); b_stop();
    chk("R4 pos", pos, 12);
    chk("R4 neg auto-inc", neg, 7);
  endtask

  task automatic t_codes();
    b_start(); b_byte(AW, 1, "R3 addr"); b_byte(8'h00, 1, "R3 ptr");
    b_byte(8'd0, 1, "R3 code0 acked"); b_stop();
    chk("R3 code0 ignored", pos, 12);
    b_start(); b_byte(AW, 1, "R3 addr"); b_byte(8'h01, 1, "R3 ptr");
    b_byte(8'd18, 1, "R3 code18 acked"); b_stop();
    chk("R3 code18 ignored", neg, 7);
    b_start(); b_byte(AW, 1, "R3 addr"); b_byte(8'h00, 1, "R3 ptr");
    b_byte(8'hE5, 1, "R3 upper bits"); b_byte(8'd17, 1, "R3 max"); b_stop();
    chk("R3 upper bits ignored", pos, 5);
    chk("R3 code17 stored", neg, 17);
  endtask

  task automatic t_mode();
    b_start(); b_byte(AW, 1, "R5 addr"); b_byte(8'h03, 1, "R5 ptr");
    b_byte(8'hF4, 1, "R5 data"); b_stop();
    chk("R5 mode forced", mode, 8'hF7);
    b_start(); b_byte(AW, 1, "R5 addr"); b_byte(8'h03, 1, "R5 ptr");
    b_byte(8'h00, 1, "R5 data"); b_stop();
    chk("R5 mode zero", mode, 8'h03);
  endtask

  task automatic t_unmapped();
    b_start(); b_byte(AW, 1, "R6 addr"); b_byte(8'h02, 1, "R6 ptr");
    b_byte(8'h55, 1, "R6 unmapped acked"); b_byte(8'h08, 1, "R6 next"); b_stop();
    chk("R6 mode after skip", mode, 8'h0B);
    chk("R6 pos untouched", pos, 5);
    chk("R6 neg untouched", neg, 17);
  endtask

  task automatic t_refused();
    b_start(); b_byte(8'h7D, 0, "R2 read nack"); b_byte(8'h00, 0, "R2 ptr nack");
    b_byte(8'd3, 0, "R2 data nack"); b_stop();
    chk("R2 read no write", pos, 5);
    b_start(); b_byte(8'h50, 0, "R2 wrong addr nack"); b_byte(8'h00, 0, "R2 ptr nack");
    b_byte(8'd3, 0, "R2 data nack"); b_stop();
    chk("R2 wrong addr no write", pos, 5);
  endtask

  task automatic t_standby();
    en_p = 1'b0; en_n = 1'b0; wq(4);
    b_start(); b_byte(AW, 0, "R8 standby nack"); b_byte(8'h00, 0, "R8 ptr nack");
    b_byte(8'd9, 0, "R8 data nack"); b_stop();
    chk("R8 standby no write", pos, 5);
    en_n = 1'b1; wq(4);
    b_start(); b_byte(AW, 1, "R8 neg-only ack"); b_byte(8'h00, 1, "R8 ptr");
    b_byte(8'd9, 1, "R8 data"); b_stop();
    chk("R8 works with one enable", pos, 9);
    en_p = 1'b1;
  endtask

  task automatic t_abort();
    b_start(); b_byte(AW, 1, "R9 addr"); b_byte(8'h00, 1, "R9 ptr");
    b_bits(8'd16, 4); b_stop();
    chk("R9 stop abort", pos, 9);
    b_start(); b_byte(AW, 1, "R9 addr"); b_byte(8'h00, 1, "R9 ptr");
    b_bits(8'd16, 5); b_start();
    chk("R9 start abort", pos, 9);
    b_byte(AW, 1, "R9 restart addr"); b_byte(8'h00, 1, "R9 ptr");
    b_byte(8'd16, 1, "R9 data"); b_stop();
    chk("R9 recovered", pos, 16);
  endtask

  task automatic t_por();
    @(negedge clk); por = 1'b1; @(negedge clk); por = 1'b0; wq(2);
    chk("R7 por pos", pos, DEF);
    chk("R7 por neg", neg, DEF);
    chk("R7 por mode", mode, 8'h03);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    wq(5); rst_n = 1'b1; wq(5);
    t_reset();
    t_write_basic();
    t_burst();
    t_codes();
    t_mode();
    t_unmapped();
    t_refused();
    t_standby();
    t_abort();
    t_por();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule